// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter and Vectorizer

The arbiter gathers every interrupt source a processor core sees and reports the one that should be taken next. The dedicated sources are a halt line, a memory-error flag, a corrected-read-data (CRD) flag, an interval-clock flag and two console flags (input and output). There are also four hardware request levels, each with a per-slot request mask, and a software request word. Every source is weighed against the core's current priority level. The highest eligible level is shown on `pend_lvl_o`, and zero there means nothing is eligible.

Pulses on the set inputs latch the dedicated flags and the hardware slot bits into internal state. The halt line and the software word are live inputs. When the core takes an interrupt it presents an acknowledge with a level. One cycle later the block returns the vector for that level and clears only the request it served. For a hardware level the vector is computed from the level and the lowest requesting slot. The fixed vectors of the dedicated sources come from parameters. An acknowledge at an upper level that has no vector source raises an error strobe.

Top module: `irq_arb`

## Requirements
- R1: After reset, with halt low and software word zero, `pend_lvl_o` is 0 at every `ipl_i` value, and `vec_vld_o` and `ack_err_o` are 0.
- R2: While `halt_i` is high, `pend_lvl_o` is 0x1F at every `ipl_i`, including 0x1F.
- R3: With halt low, the latched memory-error, CRD and clock flags report levels 0x1D, 0x1A and 0x18 respectively, in that priority order, each only when its level is strictly greater than `ipl_i`. Any nonzero `pend_lvl_o` with halt low is greater than `ipl_i`.
- R4: After the dedicated sources, hardware levels 0x17 down to 0x14 are scanned. Hardware level index k (0..3) is level 0x14+k and owns bits k*16 .. k*16+15 of `hw_set_i`. The scan ends with level 0 at the first level not greater than `ipl_i`. Otherwise the first level with a nonzero mask is reported.
- R5: If the scan passes all four hardware levels with no request, a pending console input or output flag reports level 0x14.
- R6: Otherwise, if `ipl_i` < 0x0F, the highest set bit n of `sw_req_i` with n > `ipl_i` is reported as level n. Bit 0 is never eligible, and with `ipl_i` >= 0x0F the result is 0.
- R7: An acknowledge at level 0x14+k with a nonzero mask clears only the lowest set slot s. One cycle after the acknowledge, `vec_vld_o` is 1 and `vec_o` = HW_BASE + k*0x40 + s*4. An acknowledge at a level below 0x18 that finds nothing to serve returns vector 0 with no error.
- R8: An acknowledge at 0x1D or 0x1A clears the memory-error or CRD flag and returns `VEC_MEM` or `VEC_CRD`. An acknowledge at 0x18 with the clock flag set clears it and returns `VEC_CLK`.
- R9: An acknowledge at 0x14 when hardware level 0 has no request serves console input first (returns `VEC_TTI` and clears it), otherwise console output (`VEC_TTO`).
- R10: An acknowledge at any level above 0x17 that is not served under R8 (for example 0x1F, 0x1B, or 0x18 with the clock flag clear) pulses `ack_err_o` together with `vec_vld_o`, returns vector 0 and changes no state.
- R11: A slot set pulse in the same cycle as an acknowledge that clears that slot leaves the slot set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Halt request, level sensitive |
| mem_req_i | input | 1 | Set pulse for the memory-error flag |
| crd_req_i | input | 1 | Set pulse for the CRD flag |
| clk_req_i | input | 1 | Set pulse for the clock flag |
| tti_req_i | input | 1 | Set pulse for the console input flag |
| tto_req_i | input | 1 | Set pulse for the console output flag |
| hw_set_i | input | NHW*NSLOT | Slot set pulses; level k uses bits k*NSLOT upward |
| sw_req_i | input | 16 | Software request word; bit n requests level n |
| ipl_i | input | 5 | Current processor priority level |
| ack_i | input | 1 | Acknowledge strobe |
| ack_lvl_i | input | 5 | Level being acknowledged |
| pend_lvl_o | output | 5 | Highest eligible level, 0 for none |
| vec_vld_o | output | 1 | Vector valid, one cycle after acknowledge |
| vec_o | output | VEC_W | Returned vector |
| ack_err_o | output | 1 | Acknowledge at an unserviceable upper level |

## Verification
The priority output is swept over all 32 values of `ipl_i` after each new source is added. Swept one source at a time, it shows where each source's threshold lies and whether the comparison is strict. Swept as the sources pile up, it shows the order in which they win. Walking single software bits and dense software words tell the highest-bit search apart from lowest-bit or wrong-threshold variants. Multi-slot masks acknowledged repeatedly show that slots are served lowest-first and that each acknowledge clears exactly one bit. Console, error and concurrent set-and-clear cases separate the fall-through paths of the vector logic.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 5;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_HALT   = 5'h1F;
  localparam lvl_t LVL_MEM    = 5'h1D;
  localparam lvl_t LVL_CRD    = 5'h1A;
  localparam lvl_t LVL_CLK    = 5'h18;
  localparam lvl_t LVL_HW_LO  = 5'h14;
  localparam lvl_t LVL_CON    = 5'h14;
  localparam lvl_t LVL_SW_MAX = 5'h0F;
  localparam int   SW_W       = 16;

  typedef struct packed {
    logic mem;
    logic crd;
    logic clk;
    logic tti;
    logic tto;
  } ded_t;
endpackage

// File: rtl/irq_lowest_slot.sv
module irq_lowest_slot #(
  parameter int N     = 16,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_req_state.sv
module irq_req_state
  import irq_arb_pkg::*;
#(
  parameter int NHW   = 4,
  parameter int NSLOT = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  ded_t                       ded_set_i,
  input  ded_t                       ded_clr_i,
  input  logic [NHW-1:0][NSLOT-1:0]  hw_set_i,
  input  logic [NHW-1:0][NSLOT-1:0]  hw_clr_i,
  output ded_t                       ded_q_o,
  output logic [NHW-1:0][NSLOT-1:0]  hw_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ded_q_o <= '0;
    end else begin
      // set wins over a same-cycle clear
      ded_q_o <= (ded_q_o & ~ded_clr_i) | ded_set_i;
    end
  end

  for (genvar l = 0; l < NHW; l++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hw_q_o[l] <= '0;
      else         hw_q_o[l] <= (hw_q_o[l] & ~hw_clr_i[l]) | hw_set_i[l];
    end
  end
endmodule

// File: rtl/irq_prio_eval.sv
module irq_prio_eval
  import irq_arb_pkg::*;
#(
  parameter int NHW   = 4,
  parameter int NSLOT = 16
) (
  input  logic                       halt_i,
  input  ded_t                       ded_i,
  input  logic [NHW-1:0][NSLOT-1:0]  hw_i,
  input  logic [SW_W-1:0]            sw_i,
  input  lvl_t                       ipl_i,
  output lvl_t                       pend_o
);
  logic stop;

  always_comb begin
    pend_o = '0;
    stop   = 1'b0;
    if (halt_i) begin
      pend_o = LVL_HALT;
    end else if (ded_i.mem && (ipl_i < LVL_MEM)) begin
      pend_o = LVL_MEM;
    end else if (ded_i.crd && (ipl_i < LVL_CRD)) begin
      pend_o = LVL_CRD;
    end else if (ded_i.clk && (ipl_i < LVL_CLK)) begin
      pend_o = LVL_CLK;
    end else begin
      for (int l = NHW - 1; l >= 0; l--) begin
        if (!stop) begin
          if (lvl_t'(int'(LVL_HW_LO) + l) <= ipl_i) begin
            stop = 1'b1;
          end else if (|hw_i[l]) begin
            pend_o = lvl_t'(int'(LVL_HW_LO) + l);
            stop   = 1'b1;
          end
        end
      end
      if (!stop) begin
        if ((ded_i.tti || ded_i.tto) && (ipl_i < LVL_CON)) begin
          pend_o = LVL_CON;
        end else if (ipl_i < LVL_SW_MAX) begin
          // ascending scan: the highest eligible bit is written last
          for (int b = 1; b < SW_W; b++) begin
            if (sw_i[b] && (lvl_t'(b) > ipl_i)) pend_o = lvl_t'(b);
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_ack_decode.sv
module irq_ack_decode
  import irq_arb_pkg::*;
#(
  parameter int NHW         = 4,
  parameter int NSLOT       = 16,
  parameter int VEC_W       = 12,
  parameter int VEC_HW_BASE = 'h100,
  parameter int VEC_MEM     = 'h060,
  parameter int VEC_CRD     = 'h054,
  parameter int VEC_CLK     = 'h0C0,
  parameter int VEC_TTI     = 'h0F8,
  parameter int VEC_TTO     = 'h0FC
) (
  input  logic                       ack_i,
  input  lvl_t                       ack_lvl_i,
  input  ded_t                       ded_i,
  input  logic [NHW-1:0][NSLOT-1:0]  hw_i,
  output ded_t                       ded_clr_o,
  output logic [NHW-1:0][NSLOT-1:0]  hw_clr_o,
  output logic [VEC_W-1:0]           vec_o,
  output logic                       err_o
);
  localparam int   IW        = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int   STRIDE_SH = IW + 2;
  localparam lvl_t HW_TOP    = lvl_t'(int'(LVL_HW_LO) + NHW - 1);

  logic [NHW-1:0][IW-1:0] slot_idx;
  logic [NHW-1:0]         slot_any;
  logic                   hit;

  for (genvar l = 0; l < NHW; l++) begin : g_find
    irq_lowest_slot #(.N(NSLOT)) u_find (
      .req_i (hw_i[l]),
      .idx_o (slot_idx[l]),
      .any_o (slot_any[l])
    );
  end

  always_comb begin
    ded_clr_o = '0;
    hw_clr_o  = '0;
    vec_o     = '0;
    err_o     = 1'b0;
    hit       = 1'b0;
    if (ack_i) begin
      if (ack_lvl_i == LVL_MEM) begin
        ded_clr_o.mem = 1'b1;
        vec_o = VEC_W'(VEC_MEM);
      end else if (ack_lvl_i == LVL_CRD) begin
        ded_clr_o.crd = 1'b1;
        vec_o = VEC_W'(VEC_CRD);
      end else if ((ack_lvl_i == LVL_CLK) && ded_i.clk) begin
        ded_clr_o.clk = 1'b1;
        vec_o = VEC_W'(VEC_CLK);
      end else if (ack_lvl_i > HW_TOP) begin
        err_o = 1'b1;
      end else if (ack_lvl_i >= LVL_HW_LO) begin
        for (int l = 0; l < NHW; l++) begin
          if ((ack_lvl_i == lvl_t'(int'(LVL_HW_LO) + l)) && slot_any[l]) begin
            hw_clr_o[l][slot_idx[l]] = 1'b1;
            vec_o = VEC_W'(VEC_HW_BASE) + (VEC_W'(l) << STRIDE_SH)
                    + (VEC_W'(slot_idx[l]) << 2);
            hit = 1'b1;
          end
        end
        if (!hit && (ack_lvl_i == LVL_CON)) begin
          if (ded_i.tti) begin
            ded_clr_o.tti = 1'b1;
            vec_o = VEC_W'(VEC_TTI);
          end else if (ded_i.tto) begin
            ded_clr_o.tto = 1'b1;
            vec_o = VEC_W'(VEC_TTO);
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_arb_pkg::*;
#(
  parameter int NHW         = 4,
  parameter int NSLOT       = 16,
  parameter int VEC_W       = 12,
  parameter int VEC_HW_BASE = 'h100,
  parameter int VEC_MEM     = 'h060,
  parameter int VEC_CRD     = 'h054,
  parameter int VEC_CLK     = 'h0C0,
  parameter int VEC_TTI     = 'h0F8,
  parameter int VEC_TTO     = 'h0FC
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   halt_i,
  input  logic                   mem_req_i,
  input  logic                   crd_req_i,
  input  logic                   clk_req_i,
  input  logic                   tti_req_i,
  input  logic                   tto_req_i,
  input  logic [NHW*NSLOT-1:0]   hw_set_i,
  input  logic [SW_W-1:0]        sw_req_i,
  input  logic [LVL_W-1:0]       ipl_i,
  input  logic                   ack_i,
  input  logic [LVL_W-1:0]       ack_lvl_i,
  output logic [LVL_W-1:0]       pend_lvl_o,
  output logic                   vec_vld_o,
  output logic [VEC_W-1:0]       vec_o,
  output logic                   ack_err_o
);
  ded_t                      ded_set, ded_clr, ded_q;
  logic [NHW-1:0][NSLOT-1:0] hw_set, hw_clr, hw_q;
  logic [VEC_W-1:0]          vec_d;
  logic                      err_d;

  assign ded_set.mem = mem_req_i;
  assign ded_set.crd = crd_req_i;
  assign ded_set.clk = clk_req_i;
  assign ded_set.tti = tti_req_i;
  assign ded_set.tto = tto_req_i;
  assign hw_set      = hw_set_i;

  irq_req_state #(.NHW(NHW), .NSLOT(NSLOT)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ded_set_i (ded_set),
    .ded_clr_i (ded_clr),
    .hw_set_i  (hw_set),
    .hw_clr_i  (hw_clr),
    .ded_q_o   (ded_q),
    .hw_q_o    (hw_q)
  );

  irq_prio_eval #(.NHW(NHW), .NSLOT(NSLOT)) u_prio (
    .halt_i (halt_i),
    .ded_i  (ded_q),
    .hw_i   (hw_q),
    .sw_i   (sw_req_i),
    .ipl_i  (ipl_i),
    .pend_o (pend_lvl_o)
  );

  irq_ack_decode #(
    .NHW(NHW), .NSLOT(NSLOT), .VEC_W(VEC_W), .VEC_HW_BASE(VEC_HW_BASE),
    .VEC_MEM(VEC_MEM), .VEC_CRD(VEC_CRD), .VEC_CLK(VEC_CLK),
    .VEC_TTI(VEC_TTI), .VEC_TTO(VEC_TTO)
  ) u_ack (
    .ack_i     (ack_i),
    .ack_lvl_i (ack_lvl_i),
    .ded_i     (ded_q),
    .hw_i      (hw_q),
    .ded_clr_o (ded_clr),
    .hw_clr_o  (hw_clr),
    .vec_o     (vec_d),
    .err_o     (err_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_vld_o <= 1'b0;
      vec_o     <= '0;
      ack_err_o <= 1'b0;
    end else begin
      vec_vld_o <= ack_i;
      vec_o     <= vec_d;
      ack_err_o <= err_d;
    end
  end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int NHW   = 4,
  parameter int VEC_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             halt_i,
  input logic [4:0]       ipl_i,
  input logic             ack_i,
  input logic [4:0]       ack_lvl_i,
  input logic [4:0]       pend_lvl_o,
  input logic             vec_vld_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             ack_err_o
);
  localparam logic [4:0] HW_LO  = 5'h14;
  localparam logic [4:0] HW_TOP = 5'(20 + NHW - 1);

  assert_halt_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> (pend_lvl_o == 5'h1F));

  assert_above_ipl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_i && (pend_lvl_o != 5'd0)) |-> (pend_lvl_o > ipl_i));

  assert_sw_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_lvl_o != 5'd0) && (pend_lvl_o <= 5'h0F)) |-> (ipl_i < 5'h0F));

  assert_vld_after_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> vec_vld_o);

  assert_no_vld_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !vec_vld_o);

  assert_hw_vec_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_vld_o && !ack_err_o && ($past(ack_lvl_i) >= HW_LO) &&
     ($past(ack_lvl_i) <= HW_TOP)) |-> (vec_o[1:0] == 2'b00));

  assert_err_upper_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_err_o |-> (vec_vld_o && ($past(ack_lvl_i) > HW_TOP) && (vec_o == '0)));
endmodule

bind irq_arb irq_arb_chk #(.NHW(NHW), .VEC_W(VEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .halt_i     (halt_i),
  .ipl_i      (ipl_i),
  .ack_i      (ack_i),
  .ack_lvl_i  (ack_lvl_i),
  .pend_lvl_o (pend_lvl_o),
  .vec_vld_o  (vec_vld_o),
  .vec_o      (vec_o),
  .ack_err_o  (ack_err_o)
);

// File: tb/irq_arb_test.sv
`timescale 1ns/1ps
module irq_arb_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        halt_i = 1'b0;
  logic        mem_req_i = 1'b0, crd_req_i = 1'b0, clk_req_i = 1'b0;
  logic        tti_req_i = 1'b0, tto_req_i = 1'b0;
  logic [63:0] hw_set_i = '0;
  logic [15:0] sw_req_i = '0;
  logic [4:0]  ipl_i = '0;
  logic        ack_i = 1'b0;
  logic [4:0]  ack_lvl_i = '0;
  logic [4:0]  pend_lvl_o;
  logic        vec_vld_o;
  logic [11:0] vec_o;
  logic        ack_err_o;

  int total = 0;
  int fails = 0;

  // bench-side request state
  bit        m_mem, m_crd, m_clk, m_tti, m_tto;
  bit [15:0] m_hw [4];

  always #4 clk_i = ~clk_i;

  irq_arb uut (
    .clk_i, .rst_ni, .halt_i, .mem_req_i, .crd_req_i, .clk_req_i,
    .tti_req_i, .tto_req_i, .hw_set_i, .sw_req_i, .ipl_i, .ack_i,
    .ack_lvl_i, .pend_lvl_o, .vec_vld_o, .vec_o, .ack_err_o
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int m_pend(input int ipl, input bit halt, input bit [15:0] sw);
    if (halt) return 'h1F;
    if (m_mem && ipl < 'h1D) return 'h1D;
    if (m_crd && ipl < 'h1A) return 'h1A;
    if (m_clk && ipl < 'h18) return 'h18;
    for (int l = 'h17; l >= 'h14; l--) begin
      if (l <= ipl) return 0;
      if (m_hw[l - 'h14] != 0) return l;
    end
    if (m_tti || m_tto) return 'h14;
    if (ipl >= 'h0F) return 0;
    for (int b = 15; b > ipl; b--) if (sw[b]) return b;
    return 0;
  endfunction

  task automatic sweep(input string tag);
    for (int v = 0; v < 32; v++) begin
      @(negedge clk_i);
      ipl_i = v[4:0];
      #1;
      check($sformatf("%s ipl=%0d", tag, v), int'(pend_lvl_o), m_pend(v, halt_i, sw_req_i));
    end
    @(negedge clk_i);
    ipl_i = '0;
  endtask

  task automatic pulse(input bit mem, crd, clk, tti, tto, input logic [63:0] hw);
    @(negedge clk_i);
    mem_req_i = mem; crd_req_i = crd; clk_req_i = clk;
    tti_req_i = tti; tto_req_i = tto; hw_set_i = hw;
    @(negedge clk_i);
    mem_req_i = 0; crd_req_i = 0; clk_req_i = 0;
    tti_req_i = 0; tto_req_i = 0; hw_set_i = '0;
    m_mem |= mem; m_crd |= crd; m_clk |= clk; m_tti |= tti; m_tto |= tto;
    for (int k = 0; k < 4; k++) m_hw[k] |= hw[k*16 +: 16];
  endtask

  // serves one acknowledge in the bench model
  task automatic m_ack(input int lvl, output int vec, output int err);
    vec = 0; err = 0;
    if (lvl == 'h1D) begin m_mem = 0; vec = 'h060; end
    else if (lvl == 'h1A) begin m_crd = 0; vec = 'h054; end
    else if (lvl == 'h18 && m_clk) begin m_clk = 0; vec = 'h0C0; end
    else if (lvl > 'h17) err = 1;
    else if (lvl >= 'h14) begin
      int k = lvl - 'h14;
      if (m_hw[k] != 0) begin
        int s = 0;
        while (!m_hw[k][s]) s++;
        m_hw[k][s] = 0;
        vec = 'h100 + k * 'h40 + s * 4;
      end else if (lvl == 'h14) begin
        if (m_tti) begin m_tti = 0; vec = 'h0F8; end
        else if (m_tto) begin m_tto = 0; vec = 'h0FC; end
      end
    end
  endtask

  task automatic do_ack(input string tag, input int lvl, input logic [63:0] hw);
    int ev, ee;
    m_ack(lvl, ev, ee);
    for (int k = 0; k < 4; k++) m_hw[k] |= hw[k*16 +: 16];
    @(negedge clk_i);
    ack_i = 1; ack_lvl_i = lvl[4:0]; hw_set_i = hw;
    @(negedge clk_i);
    ack_i = 0; hw_set_i = '0;
    #1;
    check({tag, " vld"}, int'(vec_vld_o), 1);
    check({tag, " vec"}, int'(vec_o), ev);
    check({tag, " err"}, int'(ack_err_o), ee);
    check({tag, " pend"}, int'(pend_lvl_o), m_pend(0, halt_i, sw_req_i));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit [15:0] pats [6] = '{16'h0001, 16'h0A50, 16'hFFFF, 16'h8001, 16'h0300, 16'h7FFE};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1 reset pend", int'(pend_lvl_o), 0);
    check("R1 reset vld", int'(vec_vld_o), 0);
    check("R1 reset err", int'(ack_err_o), 0);
    sweep("R1 idle");

    for (int b = 0; b < 16; b++) begin
      sw_req_i = 16'(1) << b;
      sweep($sformatf("R6 swbit%0d", b));
    end
    for (int p = 0; p < 6; p++) begin
      sw_req_i = pats[p];
      sweep($sformatf("R6 sw=%h", pats[p]));
    end
    sw_req_i = '0;

    pulse(0, 0, 0, 1, 0, 64'h0);
    sweep("R5 console");
    sw_req_i = 16'h8000;
    sweep("R5 console over sw");
    sw_req_i = '0;
    pulse(0, 0, 0, 0, 0, 64'h0000_0000_0000_0020);
    sweep("R4 hw0");
    pulse(0, 0, 0, 0, 0, 64'h0200_0000_0000_0000);
    sweep("R4 hw3");
    pulse(0, 0, 1, 0, 0, 64'h0);
    sweep("R3 clk");
    pulse(0, 1, 0, 0, 0, 64'h0);
    sweep("R3 crd");
    pulse(1, 0, 0, 0, 0, 64'h0);
    sweep("R3 mem");
    halt_i = 1'b1;
    sweep("R2 halt");
    halt_i = 1'b0;

    do_ack("R8 mem", 'h1D, 64'h0);
    do_ack("R8 mem again", 'h1D, 64'h0);
    do_ack("R8 crd", 'h1A, 64'h0);
    do_ack("R8 clk", 'h18, 64'h0);
    do_ack("R10 clk clear", 'h18, 64'h0);
    do_ack("R10 halt lvl", 'h1F, 64'h0);
    do_ack("R10 lvl1B", 'h1B, 64'h0);
    do_ack("R7 hw3", 'h17, 64'h0);
    pulse(0, 0, 0, 0, 0, 64'h0000_0000_8421_0000);
    sweep("R4 hw1");
    for (int i = 0; i < 4; i++) do_ack($sformatf("R7 hw1 #%0d", i), 'h15, 64'h0);
    do_ack("R7 hw1 empty", 'h15, 64'h0);
    do_ack("R7 hw0", 'h14, 64'h0);
    do_ack("R9 tti", 'h14, 64'h0);
    pulse(0, 0, 0, 1, 1, 64'h0);
    sweep("R5 both console");
    do_ack("R9 tti first", 'h14, 64'h0);
    do_ack("R9 tto", 'h14, 64'h0);
    do_ack("R9 none", 'h14, 64'h0);
    do_ack("R7 low lvl", 'h10, 64'h0);
    pulse(0, 0, 0, 0, 0, 64'h0000_0008_0000_0000);
    do_ack("R11 set wins", 'h16, 64'h0000_0008_0000_0000);
    do_ack("R11 reserved", 'h16, 64'h0);
    sweep("R1 drained");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule